// File: doc/BRIEF.md
# Free-Running Timer with Capture

A 16-bit up-counter that runs from one of four count sources chosen by an 8-bit mode register. The sources are an external tick input, every system clock, one clock in four, and one clock in thirty-two. A sampled pin can latch the running count on its rising edge, its falling edge, or both. Each time the counter wraps, the block raises a one-cycle interrupt pulse and sets a sticky overflow flag. Software clears that flag by writing zero to its bit.

A timer pin is driven from a read-only output-data bit. When inversion is enabled, that bit toggles on every overflow. An output-enable bit either drives the pin or releases it to port mode. Everything runs on a single system clock. The slower rates come from a free-running 5-bit divider whose taps act as count enables, so no derived clocks are produced. Software writes the mode register through a one-cycle write strobe and can read it back at any time, together with the live count and the capture register.

Top module: `frt_capture_timer`

## Requirements
- R1: After a synchronous reset, the mode register reads 0x00, the count and capture value are 0, and `tmr_out`, `tmr_out_en` and `ovf_irq` are low.
- R2: Mode register layout, MSB first: bit 7 output data, bit 6 overflow flag, bits 5:4 capture edge, bit 3 inversion enable, bits 2:1 count source, bit 0 output enable. A write updates bits 5:0 on the following cycle. Bit 7 ignores all writes.
- R3: Count source code 00 advances the count by one for each cycle in which `ext_tick` is high. Code 01 advances it every cycle. Code 10 advances it once every 4 cycles. Code 11 advances it once every 32 cycles. The divider phase runs freely from reset.
- R4: The count steps from 0xFFFF to 0x0000. `ovf_irq` is high for exactly the one cycle in which the count first reads 0x0000 after the wrap.
- R5: Capture edge code 00 disables capture, 01 selects rising edges of `cap_pin`, 10 falling edges and 11 both. The pin passes through two synchronizing flops. `cap_value` takes the count held in the cycle the synchronized edge is seen.
- R6: While count source code 01 is selected, pin edges never change `cap_value`.
- R7: The overflow flag is set when the counter wraps and stays set until software writes 0 to bit 6. Writing 1 to bit 6 has no effect. A wrap in the same cycle as a clearing write leaves the flag set.
- R8: With inversion enable at 1, the output-data bit toggles on every wrap. With inversion enable at 0, it holds its value.
- R9: With output enable at 0, `tmr_out` and `tmr_out_en` are low. With output enable at 1, `tmr_out_en` is high and `tmr_out` equals the output-data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Mode register write strobe |
| reg_wdata | input | 8 | Mode register write data |
| reg_rdata | output | 8 | Mode register read value, including the live flag and output-data bits |
| ext_tick | input | 1 | External count pulse, used with count source 00 |
| cap_pin | input | 1 | Asynchronous capture pin |
| count_value | output | 16 | Running count |
| cap_value | output | 16 | Last captured count |
| tmr_out | output | 1 | Timer pin level |
| tmr_out_en | output | 1 | Timer pin drive enable |
| ovf_irq | output | 1 | One-cycle overflow pulse |

## Verification
Faults in the divider or the source select appear at `count_value` within 32 cycles, as a step missing or arriving early against the reference count. A wrong synchronizer depth or a wrong edge decode shows on `cap_value` two to three cycles after a pin change, as a value latched one count off, or latched when it should not be, or not latched at all. Faults in the flag and output-data logic stay invisible until a wrap. The bench therefore drives the counter through two full wraps: one with inversion on and a clearing write landing on the wrap cycle, and one with inversion off.

// File: rtl/frt_pkg.sv
package frt_pkg;

  typedef enum logic [1:0] {
    SRC_EXT   = 2'b00,
    SRC_SYS   = 2'b01,
    SRC_DIV4  = 2'b10,
    SRC_DIV32 = 2'b11
  } cnt_src_e;

  typedef enum logic [1:0] {
    CAP_NONE = 2'b00,
    CAP_RISE = 2'b01,
    CAP_FALL = 2'b10,
    CAP_BOTH = 2'b11
  } cap_edge_e;

  // Packed MSB first; bit positions are software visible.
  typedef struct packed {
    logic      out_data;
    logic      ovf_flag;
    cap_edge_e cap_edge;
    logic      inv_en;
    cnt_src_e  cnt_src;
    logic      out_en;
  } mode_t;

endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
  parameter int DIV_W = 5,
  parameter int MID_W = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick_mid,
  output logic tick_slow
);
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  // Each tap fires once per wrap of its low-order slice.
  assign tick_mid  = &div_q[MID_W-1:0];
  assign tick_slow = &div_q;
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             ovf_pulse
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap = ce && (&cnt_q);
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      ovf_pulse <= 1'b0;
    end else begin
      if (ce) cnt_q <= cnt_q + 1'b1;
      ovf_pulse <= wrap;
    end
  end
endmodule

// File: rtl/frt_edge_capture.sv
module frt_edge_capture
  import frt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  cap_edge_e        edge_sel,
  input  logic             block,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_value
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;
  logic             synced, prev, rise, fall, hit;

  genvar g;
  generate
    for (g = 0; g < CHAIN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign synced = chain_q[SYNC_STAGES-1];
  assign prev   = chain_q[SYNC_STAGES];
  assign rise   = synced & ~prev;
  assign fall   = ~synced & prev;

  always_comb begin
    unique case (edge_sel)
      CAP_NONE: hit = 1'b0;
      CAP_RISE: hit = rise;
      CAP_FALL: hit = fall;
      default:  hit = rise | fall;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)              cap_value <= '0;
    else if (hit && !block) cap_value <= cnt;
  end
endmodule

// File: rtl/frt_capture_timer.sv
module frt_capture_timer
  import frt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_W       = 5,
  parameter int MID_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             ext_tick,
  input  logic             cap_pin,
  output logic [CNT_W-1:0] count_value,
  output logic [CNT_W-1:0] cap_value,
  output logic             tmr_out,
  output logic             tmr_out_en,
  output logic             ovf_irq
);
  mode_t            mode_q;
  mode_t            wr_view;
  logic             tick_mid, tick_slow;
  logic             ce, wrap;
  logic [CNT_W-1:0] cnt;

  assign wr_view = mode_t'(reg_wdata);

  frt_prescaler #(.DIV_W(DIV_W), .MID_W(MID_W)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .tick_mid  (tick_mid),
    .tick_slow (tick_slow)
  );

  always_comb begin
    unique case (mode_q.cnt_src)
      SRC_EXT:  ce = ext_tick;
      SRC_SYS:  ce = 1'b1;
      SRC_DIV4: ce = tick_mid;
      default:  ce = tick_slow;
    endcase
  end

  frt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .cnt       (cnt),
    .wrap      (wrap),
    .ovf_pulse (ovf_irq)
  );

  frt_edge_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .pin       (cap_pin),
    .edge_sel  (mode_q.cap_edge),
    .block     (mode_q.cnt_src == SRC_SYS),
    .cnt       (cnt),
    .cap_value (cap_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else begin
      if (reg_we) begin
        mode_q.cap_edge <= wr_view.cap_edge;
        mode_q.inv_en   <= wr_view.inv_en;
        mode_q.cnt_src  <= wr_view.cnt_src;
        mode_q.out_en   <= wr_view.out_en;
      end
      // Hardware set outranks a same-cycle software clear.
      if (wrap)                                mode_q.ovf_flag <= 1'b1;
      else if (reg_we && !wr_view.ovf_flag)    mode_q.ovf_flag <= 1'b0;
      if (wrap && mode_q.inv_en)               mode_q.out_data <= ~mode_q.out_data;
    end
  end

  assign reg_rdata   = mode_q;
  assign count_value = cnt;
  assign tmr_out_en  = mode_q.out_en;
  assign tmr_out     = mode_q.out_en & mode_q.out_data;
endmodule

// File: rtl/frt_capture_timer_chk.sv
module frt_capture_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       reg_rdata,
  input logic [CNT_W-1:0] count_value,
  input logic [CNT_W-1:0] cap_value,
  input logic             tmr_out,
  input logic             tmr_out_en,
  input logic             ovf_irq,
  input logic             reg_we,
  input logic [7:0]       reg_wdata
);
  // R4: the pulse marks the first zero after wrap
  p_irq_zero_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> count_value == '0);

  // R3: system-clock source steps every cycle
  p_sys_step_r3: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[2:1] == 2'b01 |=> (count_value - $past(count_value)) == CNT_W'(1));

  // R5: capture off keeps the register
  p_cap_off_r5: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[5:4] == 2'b00 |=> $stable(cap_value));

  // R6: undivided source blocks capture
  p_sys_nocap_r6: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[2:1] == 2'b01 |=> $stable(cap_value));

  // R7: flag stays unless cleared by a zero write
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[6] && !(reg_we && !reg_wdata[6])) |=> reg_rdata[6]);

  // R7: overflow leaves the flag set
  p_irq_flag_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> reg_rdata[6]);

  // R8: output data moves only with a wrap
  p_data_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !ovf_irq |-> $stable(reg_rdata[7]));

  // R9: pin follows data when driven, low when released
  p_pin_on_r9: assert property (@(posedge clk) disable iff (rst)
    tmr_out_en |-> tmr_out == reg_rdata[7]);
  p_pin_off_r9: assert property (@(posedge clk) disable iff (rst)
    !tmr_out_en |-> !tmr_out);
endmodule

bind frt_capture_timer frt_capture_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_rdata   (reg_rdata),
  .count_value (count_value),
  .cap_value   (cap_value),
  .tmr_out     (tmr_out),
  .tmr_out_en  (tmr_out_en),
  .ovf_irq     (ovf_irq),
  .reg_we      (reg_we),
  .reg_wdata   (reg_wdata)
);

// File: tb/tb_frt_capture_timer.sv
module tb_frt_capture_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        ext_tick = 1'b0;
  logic        cap_pin = 1'b0;
  logic [15:0] count_value, cap_value;
  logic        tmr_out, tmr_out_en, ovf_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  frt_capture_timer dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ext_tick(ext_tick), .cap_pin(cap_pin),
    .count_value(count_value), .cap_value(cap_value),
    .tmr_out(tmr_out), .tmr_out_en(tmr_out_en), .ovf_irq(ovf_irq)
  );

  // Behavioural reference
  int m_pre, m_cnt, m_cap, m_src, m_edge;
  bit m_flag, m_data, m_inv, m_oe, m_irq;
  bit m_s1, m_s2, m_s3;

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_cnt = 0; m_cap = 0; m_src = 0; m_edge = 0;
      m_flag = 0; m_data = 0; m_inv = 0; m_oe = 0; m_irq = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      bit tick, wrap, rise, fall, hit;
      case (m_src)
        0: tick = ext_tick;
        1: tick = 1;
        2: tick = (m_pre % 4) == 3;
        default: tick = (m_pre == 31);
      endcase
      wrap = tick && (m_cnt == 65535);
      rise = m_s2 && !m_s3;
      fall = !m_s2 && m_s3;
      hit  = (m_edge == 1 && rise) || (m_edge == 2 && fall) || (m_edge == 3 && (rise || fall));
      if (hit && m_src != 1) m_cap = m_cnt;
      if (tick) m_cnt = (m_cnt + 1) % 65536;
      m_irq = wrap;
      if (wrap) m_flag = 1;
      else if (reg_we && !reg_wdata[6]) m_flag = 0;
      if (wrap && m_inv) m_data = !m_data;
      if (reg_we) begin
        m_edge = reg_wdata[5:4]; m_inv = reg_wdata[3];
        m_src = reg_wdata[2:1];  m_oe = reg_wdata[0];
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_pin;
      m_pre = (m_pre + 1) % 32;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R3 count",     count_value, m_cnt);
      check("R5 capture",   cap_value, m_cap);
      check("R2 mode read", reg_rdata, {m_data, m_flag, m_edge[1:0], m_inv, m_src[1:0], m_oe});
      check("R4 irq",       ovf_irq, m_irq);
      check("R9 pin",       tmr_out, m_oe && m_data);
      check("R9 pin en",    tmr_out_en, m_oe);
    end
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] c0, held;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 count", count_value, 0);
    check("R1 cap", cap_value, 0);
    check("R1 outs", {tmr_out, tmr_out_en, ovf_irq}, 3'b000);

    // R3 external ticks: 8 pulses in mixed spacing
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); ext_tick = 1'b1;
      @(negedge clk); ext_tick = 1'b0;
      idle(2);
    end
    @(negedge clk); ext_tick = 1'b1;
    idle(3);
    ext_tick = 1'b0;
    idle(1);
    check("R3 ext count", count_value, 8);

    // R2 bit 7 ignores writes; R7 writing 1 to flag leaves it clear
    wr(8'hFF);
    check("R2 bit7 read-only", reg_rdata, 8'h3F);
    check("R9 enabled pin level", {tmr_out_en, tmr_out}, 2'b10);

    // R3 rates
    wr(8'h02);
    c0 = count_value; idle(10);
    check("R3 sys rate", count_value - c0, 10);
    wr(8'h04);
    c0 = count_value; idle(32);
    check("R3 div4 rate", count_value - c0, 8);
    wr(8'h06);
    c0 = count_value; idle(64);
    check("R3 div32 rate", count_value - c0, 2);

    // R5 capture edges, counting by 4
    wr(8'h14);
    @(negedge clk); cap_pin = 1'b1; idle(6);
    check("R5 rising capture", cap_value, m_cap);
    held = cap_value;
    @(negedge clk); cap_pin = 1'b0; idle(6);
    check("R5 falling ignored under rising", cap_value, held);
    wr(8'h24);
    idle(8);
    @(negedge clk); cap_pin = 1'b1; idle(6);
    check("R5 rising ignored under falling", cap_value, held);
    @(negedge clk); cap_pin = 1'b0; idle(6);
    check("R5 falling capture", cap_value, m_cap);
    wr(8'h34);
    idle(8);
    @(negedge clk); cap_pin = 1'b1; idle(6);
    check("R5 both rising", cap_value, m_cap);
    idle(8);
    @(negedge clk); cap_pin = 1'b0; idle(6);
    check("R5 both falling", cap_value, m_cap);
    held = cap_value;
    wr(8'h04);
    @(negedge clk); cap_pin = 1'b1; idle(6);
    @(negedge clk); cap_pin = 1'b0; idle(6);
    check("R5 capture disabled", cap_value, held);
    // R6 undivided source blocks capture
    wr(8'h32);
    @(negedge clk); cap_pin = 1'b1; idle(6);
    @(negedge clk); cap_pin = 1'b0; idle(6);
    check("R6 no capture on sys clock", cap_value, held);

    // Wrap 1: inversion on, clearing write lands on the wrap edge
    wr(8'h0B);
    while (count_value != 16'hFFFF) @(negedge clk);
    reg_we = 1'b1; reg_wdata = 8'h0B;
    @(negedge clk); reg_we = 1'b0;
    check("R4 wrap to zero", count_value, 0);
    check("R4 irq on wrap", ovf_irq, 1);
    check("R7 set beats clear", reg_rdata[6], 1);
    check("R8 toggled on wrap", reg_rdata[7], 1);
    check("R9 pin shows data", tmr_out, 1);
    @(negedge clk);
    check("R4 irq one cycle", ovf_irq, 0);
    check("R7 flag sticky", reg_rdata[6], 1);

    // R7 clear, R9 release
    wr(8'h0A);
    check("R7 cleared", reg_rdata, 8'h8A);
    check("R9 released", {tmr_out_en, tmr_out}, 2'b00);
    wr(8'h4A);
    check("R7 write one no effect", reg_rdata[6], 0);

    // Wrap 2: inversion off
    wr(8'h03);
    while (count_value != 16'hFFFF) @(negedge clk);
    @(negedge clk);
    check("R7 set again", reg_rdata[6], 1);
    check("R8 held without inversion", reg_rdata[7], 1);
    check("R9 pin high", tmr_out, 1);
    idle(2);
    finish_run();
  end
endmodule